// File: doc/BRIEF.md
# Double-Buffered Serial Data Register

This block is the data-holding part of an 8-bit synchronous serial or two-wire bus controller. The CPU sees one data port, but three registers sit behind it: a transmit buffer that the CPU fills, a receive buffer that the CPU drains, and a shift register that the bus engine clocks out or fills. A separate bus engine handles the bit-level line sequencing. It reports frame completion, start detection and stop detection as single-cycle strobes, and it exposes the raw received bits in parallel.

When a frame ends, data moves between the shift register and the buffers without any help from the CPU. Two flags track the buffers: a transmit-empty flag and a receive-full flag. Bus events and CPU accesses set and clear these flags. A frame can be 1 to 8 bits long. When a frame is shorter than the full width, a bit-order select decides which end of the byte carries the valid bits. The CPU gets one interrupt request, which depends on the flag that matters in the current direction.

Top module: `serial_dbuf`

## Requirements
- R1: A CPU write in transmit mode loads the transmit buffer only. In transmit mode a read returns the transmit buffer. `shift_out` stays unchanged until a frame ends.
- R2: A frame end in transmit mode with `tx_empty`=0 copies the transmit buffer into the shift register and sets `tx_empty`. A frame end with `tx_empty`=1 leaves `shift_out` unchanged.
- R3: A frame end in receive mode with `rx_full`=0 loads the received bits into the shift register and the receive buffer and sets `rx_full`. In receive mode a read returns the receive buffer.
- R4: An enabled CPU write in transmit mode clears `tx_empty`. An enabled CPU read in receive mode clears `rx_full` and `overrun`.
- R5: `tx_empty` is set in three cases: a start strobe arrives in transmit mode; `xmit_mode` rises while `fmt_none`=1; or `xmit_mode` rises after a start was seen and before a stop. Without one of these, a rise of `xmit_mode` does not set it.
- R6: A stop strobe clears `tx_empty`. It also ends the "start seen" state. The clear wins over any set in the same cycle.
- R7: A frame holds N bits. `frm_len`=0 gives N=8 and any other value gives N=`frm_len`. On a transmit load with `lsb_first`=0, the top N bits of the buffer are kept and the rest are zeroed. With `lsb_first`=1, the low N bits are kept.
- R8: On a receive load with `lsb_first`=0, the low N bits of `shift_in` are kept. With `lsb_first`=1, the high N bits are kept. The other bits read as 0.
- R9: A frame end in receive mode with `rx_full`=1 leaves the receive buffer unchanged. The incoming bits stay in the shift register (`shift_out`) and `overrun` is set.
- R10: While `mod_en`=0, `cpu_rdata` is 0 and CPU writes and reads change no buffer and no flag.
- R11: `irq` = (`tx_empty` AND `xmit_mode`) OR (`rx_full` AND NOT `xmit_mode`).
- R12: After reset, `tx_empty`, `rx_full`, `overrun`, `irq` and `shift_out` are all 0.
- R13: When a CPU write and a transmit frame end fall in the same cycle, the shift register takes the old buffer value, the buffer takes the new value, and `tx_empty` ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; gates CPU access |
| xmit_mode | input | 1 | 1 = transmit, 0 = receive |
| fmt_none | input | 1 | 1 = no bus format in use |
| lsb_first | input | 1 | Bit-order select |
| frm_len | input | 3 | Frame bits, 0 means 8 |
| cpu_wr | input | 1 | Data register write strobe |
| cpu_rd | input | 1 | Data register read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| evt_frame_done | input | 1 | Frame-complete strobe |
| evt_start | input | 1 | Start-detected strobe |
| evt_stop | input | 1 | Stop-detected strobe |
| shift_in | input | 8 | Received bits from the bus engine |
| shift_out | output | 8 | Shift register contents |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer full |
| overrun | output | 1 | Received frame held back |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first pair is a CPU write and a transmit frame end. The bench drives both strobes on one edge. It then expects the shift register to hold the previous buffer value, a read-back to return the new byte, and `tx_empty` to read 0. The second pair is a stop and a frame end. The bench drives them together and expects the transfer to happen while the flag stays clear. In receive mode, a frame that arrives while the buffer is full shows whether the held bits in the shift register stay apart from the older byte still in the buffer.

// File: rtl/serial_dbuf.sv
module serial_dbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_en,
  input  logic          xmit_mode,
  input  logic          fmt_none,
  input  logic          lsb_first,
  input  logic [2:0]    frm_len,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          evt_frame_done,
  input  logic          evt_start,
  input  logic          evt_stop,
  input  logic [DW-1:0] shift_in,
  output logic [DW-1:0] shift_out,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          overrun,
  output logic          irq
);
  localparam int NW = $clog2(DW) + 1;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic [DW-1:0] tx_buf, rx_buf, shreg;
  logic          xmit_q, started;

  logic [NW-1:0] nbits;
  logic [DW-1:0] mask_lo, mask_hi, tx_mask, rx_mask;

  assign nbits   = (frm_len == 3'd0) ? NW'(DW) : NW'(frm_len);
  assign mask_lo = ONES >> (NW'(DW) - nbits);
  assign mask_hi = ~(ONES >> nbits);
  assign tx_mask = lsb_first ? mask_lo : mask_hi;
  assign rx_mask = lsb_first ? mask_hi : mask_lo;

  logic wr_tx, rd_rx, tx_move, rx_move, rx_block, xmit_rise, tx_set, tx_clr;

  assign wr_tx     = mod_en & cpu_wr & xmit_mode;
  assign rd_rx     = mod_en & cpu_rd & ~xmit_mode;
  assign tx_move   = evt_frame_done & xmit_mode & ~tx_empty;
  assign rx_move   = evt_frame_done & ~xmit_mode & ~rx_full;
  assign rx_block  = evt_frame_done & ~xmit_mode & rx_full;
  assign xmit_rise = xmit_mode & ~xmit_q;
  assign tx_set    = tx_move | (evt_start & xmit_mode)
                   | (xmit_rise & (fmt_none | started));
  assign tx_clr    = wr_tx | evt_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf   <= '0;
      rx_buf   <= '0;
      shreg    <= '0;
      xmit_q   <= 1'b0;
      started  <= 1'b0;
      tx_empty <= 1'b0;
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      xmit_q <= xmit_mode;
      if (evt_stop)       started <= 1'b0;
      else if (evt_start) started <= 1'b1;

      if (wr_tx) tx_buf <= cpu_wdata;
      if (tx_move) shreg <= tx_buf & tx_mask;
      else if (evt_frame_done & ~xmit_mode) shreg <= shift_in & rx_mask;
      if (rx_move) rx_buf <= shift_in & rx_mask;

      tx_empty <= (tx_empty | tx_set) & ~tx_clr;
      rx_full  <= rx_move | (rx_full & ~rd_rx);
      overrun  <= rx_block | (overrun & ~rd_rx);
    end
  end

  assign shift_out = shreg;
  assign cpu_rdata = !mod_en ? '0 : (xmit_mode ? tx_buf : rx_buf);
  assign irq       = (tx_empty & xmit_mode) | (rx_full & ~xmit_mode);
endmodule

module serial_dbuf_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mod_en,
  input logic          xmit_mode,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic          evt_frame_done,
  input logic          evt_stop,
  input logic [DW-1:0] shift_out,
  input logic [DW-1:0] rx_buf,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          overrun
);
  p_wr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en && cpu_wr && xmit_mode |=> !tx_empty);

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !tx_empty);

  p_rx_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_done && !xmit_mode && !rx_full |=> rx_full);

  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_done && !xmit_mode && rx_full |=> overrun && $stable(rx_buf));

  p_tx_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_done && xmit_mode && tx_empty |=> $stable(shift_out));

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en && cpu_rd && !xmit_mode && !evt_frame_done |=> rx_full == $past(rx_full));
endmodule

bind serial_dbuf serial_dbuf_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .xmit_mode(xmit_mode),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .evt_frame_done(evt_frame_done),
  .evt_stop(evt_stop), .shift_out(shift_out), .rx_buf(rx_buf),
  .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun)
);

// File: tb/serial_dbuf_tb.sv
module serial_dbuf_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mod_en = 1'b1, xmit_mode = 1'b0, fmt_none = 1'b0, lsb_first = 1'b0;
  logic [2:0] frm_len = 3'd0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata, shift_in = '0, shift_out;
  logic evt_frame_done = 1'b0, evt_start = 1'b0, evt_stop = 1'b0;
  logic tx_empty, rx_full, overrun, irq;

  always #2.5 clk = ~clk;

  serial_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .xmit_mode(xmit_mode),
    .fmt_none(fmt_none), .lsb_first(lsb_first), .frm_len(frm_len),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .evt_frame_done(evt_frame_done), .evt_start(evt_start), .evt_stop(evt_stop),
    .shift_in(shift_in), .shift_out(shift_out), .tx_empty(tx_empty),
    .rx_full(rx_full), .overrun(overrun), .irq(irq)
  );

  typedef struct { string req; int kind; logic [7:0] exp; } item_t;
  item_t q[$];
  event chk_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [7:0] observe(int kind);
    case (kind)
      0: return {7'd0, tx_empty};
      1: return {7'd0, rx_full};
      2: return {7'd0, overrun};
      3: return {7'd0, irq};
      4: return shift_out;
      default: return cpu_rdata;
    endcase
  endfunction

  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = observe(it.kind);
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_v(string req, int kind, logic [7:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic judge();
    -> chk_ev;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; evt_frame_done = 0; evt_start = 0; evt_stop = 0;
  endtask

  task automatic wr(logic [7:0] d); cpu_wr = 1; cpu_wdata = d; step(); endtask
  task automatic rd(); cpu_rd = 1; step(); endtask
  task automatic frame(logic [7:0] s); evt_frame_done = 1; shift_in = s; step(); endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_v("R12", 0, 0); expect_v("R12", 1, 0); expect_v("R12", 2, 0);
    expect_v("R12", 3, 0); expect_v("R12", 4, 0); judge();

    xmit_mode = 1; step();
    expect_v("R5 plain rise", 0, 0); judge();
    evt_start = 1; step();
    expect_v("R5 start", 0, 1); expect_v("R11 tx", 3, 1); judge();

    wr(8'hA5);
    expect_v("R4 wr", 0, 0); expect_v("R1 readback", 5, 8'hA5);
    expect_v("R1 shift", 4, 8'h00); judge();

    frame(8'h00);
    expect_v("R2 move", 4, 8'hA5); expect_v("R2 flag", 0, 1); judge();
    frame(8'h00);
    expect_v("R2 idle", 4, 8'hA5); judge();

    wr(8'h3C);
    cpu_wr = 1; cpu_wdata = 8'h5A; evt_frame_done = 1; step();
    expect_v("R13 shift", 4, 8'h3C); expect_v("R13 flag", 0, 0);
    expect_v("R13 buf", 5, 8'h5A); judge();

    frm_len = 3; frame(8'h00);
    expect_v("R7 msb", 4, 8'h40); judge();
    wr(8'hFF); lsb_first = 1; frame(8'h00);
    expect_v("R7 lsb", 4, 8'h07); judge();
    frm_len = 0; lsb_first = 0; wr(8'h81); frame(8'h00);
    expect_v("R7 full", 4, 8'h81); expect_v("R2 flag", 0, 1); judge();

    evt_stop = 1; step();
    expect_v("R6 stop", 0, 0); judge();
    wr(8'h11);
    evt_frame_done = 1; evt_stop = 1; step();
    expect_v("R6 shift", 4, 8'h11); expect_v("R6 wins", 0, 0); judge();

    xmit_mode = 0; fmt_none = 1; step();
    xmit_mode = 1; step();
    expect_v("R5 nofmt", 0, 1); judge();
    fmt_none = 0; wr(8'h22);
    xmit_mode = 0; step(); xmit_mode = 1; step();
    expect_v("R5 no start", 0, 0); judge();
    xmit_mode = 0; evt_start = 1; step();
    xmit_mode = 1; step();
    expect_v("R5 switch", 0, 1); judge();

    xmit_mode = 0; frame(8'hC3);
    expect_v("R3 full", 1, 1); expect_v("R3 data", 5, 8'hC3);
    expect_v("R11 rx", 3, 1); judge();
    rd();
    expect_v("R4 rd", 1, 0); expect_v("R11 off", 3, 0); judge();

    frm_len = 4; frame(8'hBE);
    expect_v("R8 low", 5, 8'h0E); judge();
    rd(); lsb_first = 1; frame(8'hBE);
    expect_v("R8 high", 5, 8'hB0); judge();
    frame(8'h7C);
    expect_v("R9 ovr", 2, 1); expect_v("R9 buf", 5, 8'hB0);
    expect_v("R9 shift", 4, 8'h70); expect_v("R9 full", 1, 1); judge();
    rd();
    expect_v("R9 clr", 2, 0); expect_v("R4 rd", 1, 0); judge();

    frame(8'hFF); mod_en = 0;
    expect_v("R10 rdata", 5, 8'h00); judge();
    rd();
    expect_v("R10 rd", 1, 1); judge();
    xmit_mode = 1; step();
    expect_v("R5 switch2", 0, 1); judge();
    cpu_wr = 1; cpu_wdata = 8'h99; step();
    expect_v("R10 wr", 0, 1); judge();
    mod_en = 1; step();
    expect_v("R10 buf", 5, 8'h22); judge();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule